// File: doc/BRIEF.md
# Zone-Parity Carrier-Selecting PWM Modulator

This block drives the legs of a multi-phase inverter in which every phase is built from several legs wired in parallel and interleaved. For each phase it compares one signed reference against one carrier per leg. The block receives two sets of phase-shifted carriers and decides, for each phase on its own, which set that phase uses. With this choice the line-to-line voltage only steps between adjacent levels.

First, a common-mode offset equal to minus half the sum of the largest and smallest phase references is added to every reference. This stretches the linear range. Each adjusted reference is saturated to full scale and placed into one of `LEGS` equal zones. The parity of the zone picks the carrier set. Zone and set are reloaded only on the cycle that marks a carrier period boundary, so a phase never swaps sets in the middle of a period. A bypass input pins every phase to the first set, which gives conventional single-set interleaved PWM for comparison.

References and carriers share one signed fixed-point scale of `W` bits. The value +1 is represented by FS = 2^(W-2).

Top module: `zone_pwm`

## Requirements
- R1: While rst_ni is low, every gate output is 0, every zone output is 1 and every select output is 0.
- R2: The adjusted reference of phase p is ref_p - floor((max+min)/2), where max and min are taken over all phase references in the same cycle.
- R3: The adjusted reference is saturated to the range [-FS, +FS]. Its zone is z = 1 + floor((a+FS)*LEGS/(2*FS)), limited to LEGS, so a = +FS lands in zone LEGS and a = -FS lands in zone 1.
- R4: On a boundary cycle with bypass low, select = z mod 2. Select 0 routes set 1 (car1_i) and select 1 routes set 2 (car2_i).
- R5: Zone and select outputs load only on a clock edge at which period_start_i is high. Otherwise they hold.
- R6: gate_o[p*LEGS+k] is registered. It is 1 exactly when the phase's adjusted, saturated reference is greater than or equal to carrier k of the set in force after that edge. On a boundary edge this is the newly loaded set.
- R7: On a boundary cycle with bypass_i high, every select loads 0 (set 1) whatever its zone, and the zone still loads.
- R8: Each phase loads its own zone and select. Phases in different zones carry different selects in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | PHASES*W | Signed phase references; phase p occupies bits [p*W +: W] |
| car1_i | input | LEGS*W | Carrier set 1; leg k occupies bits [k*W +: W] |
| car2_i | input | LEGS*W | Carrier set 2, same layout as car1_i |
| period_start_i | input | 1 | High for one cycle at each carrier period boundary |
| bypass_i | input | 1 | Forces set 1 for all phases at the next boundary |
| gate_o | output | PHASES*LEGS | Leg commands; phase p, leg k at bit p*LEGS+k |
| zone_o | output | PHASES*ZW | Zone index 1..LEGS per phase, phase p at [p*ZW +: ZW], ZW = $clog2(LEGS+1) |
| sel_o | output | PHASES | Carrier set select per phase (0 = set 1, 1 = set 2) |

## Verification
The reload of zone and carrier set and the leg comparison can fall in the same cycle, because a boundary edge also registers the gates. The bench provokes this by raising period_start_i in the same cycle that the references jump into a zone of the opposite parity, with the two carrier sets placed so that they give different gate patterns. It judges the result against a model that loads the new set first and then compares. The same coincidence is repeated with bypass high, where the zone must change but the set must stay at set 1.

// File: rtl/zone_pwm_pkg.sv
package zone_pwm_pkg;
  localparam logic SET_ONE = 1'b0;
  localparam logic SET_TWO = 1'b1;
endpackage

// File: rtl/zs_offset.sv
module zs_offset #(
  parameter int PHASES = 3,
  parameter int W      = 16,
  localparam int AW    = W + 2
) (
  input  logic [PHASES*W-1:0]  ref_i,
  output logic [PHASES*AW-1:0] adj_o
);
  logic signed [W-1:0] mx, mn, half;
  logic signed [W:0]   sum;

  always_comb begin
    mx = $signed(ref_i[W-1:0]);
    mn = $signed(ref_i[W-1:0]);
    for (int p = 1; p < PHASES; p++) begin
      if ($signed(ref_i[p*W +: W]) > mx) mx = $signed(ref_i[p*W +: W]);
      if ($signed(ref_i[p*W +: W]) < mn) mn = $signed(ref_i[p*W +: W]);
    end
    sum  = {mx[W-1], mx} + {mn[W-1], mn};
    half = sum[W:1]; // floor of sum/2
  end

  for (genvar p = 0; p < PHASES; p++) begin : g_adj
    logic [W-1:0] r;
    assign r = ref_i[p*W +: W];
    assign adj_o[p*AW +: AW] = {{2{r[W-1]}}, r} - {{2{half[W-1]}}, half};
  end
endmodule

// File: rtl/zone_quant.sv
module zone_quant #(
  parameter int W    = 16,
  parameter int LEGS = 3,
  localparam int AW  = W + 2,
  localparam int ZW  = $clog2(LEGS + 1)
) (
  input  logic signed [AW-1:0] adj_i,
  output logic signed [W-1:0]  sat_o,
  output logic [ZW-1:0]        zone_o
);
  localparam logic signed [AW-1:0] FS_P = {{(AW-W+1){1'b0}}, 1'b1, {(W-2){1'b0}}};
  localparam logic signed [AW-1:0] FS_N = -FS_P;
  localparam logic [W-1:0]         FS_U = FS_P[W-1:0];

  logic signed [AW-1:0] sat_w;
  logic [W-1:0]         u;
  logic [W+ZW-1:0]      prod;
  logic [ZW:0]          zq;

  always_comb begin
    if (adj_i > FS_P)      sat_w = FS_P;
    else if (adj_i < FS_N) sat_w = FS_N;
    else                   sat_w = adj_i;
    sat_o = sat_w[W-1:0];
    u     = $unsigned(sat_o) + FS_U;        // 0 .. 2*FS
    prod  = {{ZW{1'b0}}, u} * (W+ZW)'(LEGS);
    zq    = prod[W+ZW-1:W-1];               // divide by 2*FS
    if (zq >= (ZW+1)'(LEGS)) zone_o = ZW'(LEGS);
    else                     zone_o = zq[ZW-1:0] + ZW'(1);
  end
endmodule

// File: rtl/leg_cmp.sv
module leg_cmp #(
  parameter int W    = 16,
  parameter int LEGS = 3
) (
  input  logic                sel_i,
  input  logic signed [W-1:0] ref_i,
  input  logic [LEGS*W-1:0]   car1_i,
  input  logic [LEGS*W-1:0]   car2_i,
  output logic [LEGS-1:0]     gate_o
);
  import zone_pwm_pkg::*;
  for (genvar k = 0; k < LEGS; k++) begin : g_leg
    logic signed [W-1:0] car;
    assign car       = (sel_i == SET_TWO) ? $signed(car2_i[k*W +: W]) : $signed(car1_i[k*W +: W]);
    assign gate_o[k] = (ref_i >= car);
  end
endmodule

// File: rtl/zone_pwm.sv
module zone_pwm #(
  parameter int PHASES = 3,
  parameter int LEGS   = 3,
  parameter int W      = 16,
  localparam int AW    = W + 2,
  localparam int ZW    = $clog2(LEGS + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [PHASES*W-1:0]    ref_i,
  input  logic [LEGS*W-1:0]      car1_i,
  input  logic [LEGS*W-1:0]      car2_i,
  input  logic                   period_start_i,
  input  logic                   bypass_i,
  output logic [PHASES*LEGS-1:0] gate_o,
  output logic [PHASES*ZW-1:0]   zone_o,
  output logic [PHASES-1:0]      sel_o
);
  import zone_pwm_pkg::*;

  logic [PHASES*AW-1:0]   adj;
  logic [PHASES*LEGS-1:0] gate_d;
  logic [PHASES*ZW-1:0]   zone_d, zone_q;
  logic [PHASES-1:0]      sel_d, sel_q;

  zs_offset #(.PHASES(PHASES), .W(W)) i_offset (.ref_i(ref_i), .adj_o(adj));

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    logic signed [W-1:0] sat;
    logic [ZW-1:0]       zone_now;

    zone_quant #(.W(W), .LEGS(LEGS)) i_quant (
      .adj_i (adj[p*AW +: AW]),
      .sat_o (sat),
      .zone_o(zone_now)
    );

    // new decision only at a period boundary
    assign zone_d[p*ZW +: ZW] = period_start_i ? zone_now : zone_q[p*ZW +: ZW];
    assign sel_d[p] = !period_start_i ? sel_q[p] :
                      bypass_i        ? SET_ONE  : zone_now[0];

    leg_cmp #(.W(W), .LEGS(LEGS)) i_cmp (
      .sel_i (sel_d[p]),
      .ref_i (sat),
      .car1_i(car1_i),
      .car2_i(car2_i),
      .gate_o(gate_d[p*LEGS +: LEGS])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < PHASES; p++) zone_q[p*ZW +: ZW] <= ZW'(1);
      sel_q  <= '0;
      gate_o <= '0;
    end else begin
      zone_q <= zone_d;
      sel_q  <= sel_d;
      gate_o <= gate_d;
    end
  end

  assign zone_o = zone_q;
  assign sel_o  = sel_q;
endmodule

// File: rtl/zone_pwm_chk.sv
module zone_pwm_chk #(
  parameter int PHASES = 3,
  parameter int LEGS   = 3,
  parameter int W      = 16,
  localparam int ZW    = $clog2(LEGS + 1)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   period_start_i,
  input logic                   bypass_i,
  input logic [PHASES*ZW-1:0]   zone_o,
  input logic [PHASES-1:0]      sel_o
);
  a_r5_hold_between_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !period_start_i |=> $stable(sel_o) && $stable(zone_o));

  a_r7_bypass_forces_set1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_start_i && bypass_i |=> sel_o == '0);

  for (genvar p = 0; p < PHASES; p++) begin : g_chk
    a_r4_sel_is_parity: assert property (@(posedge clk_i) disable iff (!rst_ni)
      period_start_i && !bypass_i |=> sel_o[p] == zone_o[p*ZW]);

    a_r3_zone_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      zone_o[p*ZW +: ZW] != '0 && zone_o[p*ZW +: ZW] <= ZW'(LEGS));
  end
endmodule

bind zone_pwm zone_pwm_chk #(.PHASES(PHASES), .LEGS(LEGS), .W(W)) i_zone_pwm_chk (.*);

// File: tb/test_zone_pwm.sv
`timescale 1ns/1ps
module test_zone_pwm;
  localparam int PHASES = 3;
  localparam int LEGS   = 3;
  localparam int W      = 16;
  localparam int ZW     = $clog2(LEGS + 1);
  localparam int FS     = 1 << (W - 2);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ps = 1'b0, byp = 1'b0;
  logic [PHASES*W-1:0]    ref_i;
  logic [LEGS*W-1:0]      car1_i, car2_i;
  logic [PHASES*LEGS-1:0] gate_o;
  logic [PHASES*ZW-1:0]   zone_o;
  logic [PHASES-1:0]      sel_o;

  int refs[PHASES];
  int c1[LEGS], c2[LEGS];
  int mz[PHASES], ms[PHASES];
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int p = 0; p < PHASES; p++) ref_i[p*W +: W] = W'(refs[p]);
    for (int k = 0; k < LEGS; k++) begin
      car1_i[k*W +: W] = W'(c1[k]);
      car2_i[k*W +: W] = W'(c2[k]);
    end
  end

  zone_pwm #(.PHASES(PHASES), .LEGS(LEGS), .W(W)) i_zone_pwm (
    .clk_i(clk), .rst_ni(rst_ni), .ref_i(ref_i), .car1_i(car1_i), .car2_i(car2_i),
    .period_start_i(ps), .bypass_i(byp), .gate_o(gate_o), .zone_o(zone_o), .sel_o(sel_o));

  function automatic int adj_of(int p);
    int mx = refs[0], mn = refs[0], a;
    for (int q = 1; q < PHASES; q++) begin
      if (refs[q] > mx) mx = refs[q];
      if (refs[q] < mn) mn = refs[q];
    end
    a = refs[p] - ((mx + mn) >>> 1);
    if (a > FS) a = FS;
    if (a < -FS) a = -FS;
    return a;
  endfunction

  function automatic int zone_of(int a);
    int z = 1 + ((a + FS) * LEGS) / (2 * FS);
    return (z > LEGS) ? LEGS : z;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one clock with given strobe/bypass, then compare all outputs
  task automatic cyc(string tag, logic ps_v, logic byp_v);
    ps = ps_v; byp = byp_v;
    @(posedge clk);
    if (ps_v) for (int p = 0; p < PHASES; p++) begin
      mz[p] = zone_of(adj_of(p));
      ms[p] = byp_v ? 0 : mz[p] % 2;
    end
    #1;
    for (int p = 0; p < PHASES; p++) begin
      chk(tag, $sformatf("zone p%0d", p), int'(zone_o[p*ZW +: ZW]), mz[p]);
      chk(tag, $sformatf("sel p%0d", p), int'(sel_o[p]), ms[p]);
      for (int k = 0; k < LEGS; k++)
        chk(tag, $sformatf("gate p%0d l%0d", p, k), int'(gate_o[p*LEGS+k]),
            int'(adj_of(p) >= (ms[p] ? c2[k] : c1[k])));
    end
    ps = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    chk("R1", "gate", int'(gate_o), 0);
    chk("R1", "sel", int'(sel_o), 0);
    for (int p = 0; p < PHASES; p++) begin
      chk("R1", "zone", int'(zone_o[p*ZW +: ZW]), 1);
      mz[p] = 1; ms[p] = 0;
    end
  endtask

  task automatic t_offset;
    refs = '{12000, -4000, -4000}; cyc("R2", 1, 0);
    refs = '{10000, 2000, -6000};  cyc("R2", 1, 0);
    refs = '{-9000, 7001, 3000};   cyc("R2", 1, 0);
  endtask

  task automatic t_saturate;
    refs = '{30000, -30000, 0}; cyc("R3", 1, 0);
    refs = '{FS, -FS, 0};       cyc("R3", 1, 0);
    chk("R3", "zone at +FS", int'(zone_o[ZW-1:0]), LEGS);
    chk("R3", "zone at -FS", int'(zone_o[ZW +: ZW]), 1);
  endtask

  task automatic t_parity;
    c1 = '{-3000, 1000, 5000}; c2 = '{-1000, 3000, 7000};
    refs = '{4000, 0, -4000}; cyc("R4", 1, 0);
    refs = '{14000, 2000, -16000}; cyc("R4", 1, 0);
  endtask

  task automatic t_hold;
    refs = '{-14000, 0, 14000}; cyc("R5", 1, 0);
    refs = '{14000, 0, -14000}; cyc("R5", 0, 0);
    refs = '{2000, 1000, -1000}; cyc("R5", 0, 0);
    cyc("R5", 1, 0);
  endtask

  task automatic t_bypass;
    refs = '{14000, 0, -14000}; cyc("R7", 1, 1);
    refs = '{-3000, 0, 3000};  cyc("R7", 0, 1);
    refs = '{14000, 0, -14000}; cyc("R7", 1, 0);
  endtask

  task automatic t_indep;
    refs = '{12000, 0, -12000}; cyc("R8", 1, 0);
    chk("R8", "sel pattern", int'(sel_o), 3'b101);
  endtask

  task automatic t_boundary;
    c1 = '{-2000, 2000, 6000}; c2 = '{0, 4000, 8000};
    refs = '{-12000, 0, 12000}; cyc("R6", 1, 0);
    refs = '{3000, 1000, -13000}; cyc("R6", 1, 0);
    refs = '{15000, 0, -9000};   cyc("R6", 1, 1);
    for (int s = 0; s < 24; s++) begin
      for (int k = 0; k < LEGS; k++) begin
        c1[k] = -FS + ((s * 1500 + k * 10922) % (2 * FS));
        c2[k] = -FS + ((s * 1500 + k * 10922 + 5461) % (2 * FS));
      end
      refs = '{(s * 1300) % FS - 6000, 500 - s * 200, s * 400 - 4000};
      cyc("R6", (s % 8) == 0, 0);
    end
  endtask

  initial begin
    refs = '{0, 0, 0}; c1 = '{0, 0, 0}; c2 = '{0, 0, 0};
    repeat (3) @(posedge clk);
    t_reset;
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #1;
    t_offset; t_saturate; t_parity; t_hold; t_bypass; t_indep; t_boundary;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100us;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule